// File: doc/BRIEF.md
# ECC-Protected Store Buffer

This block holds up to eight pending stores for one hardware thread. Each fill carries an address, an 8-bit byte mask or alternate-space number, 64 bits of data, an alternate-space flag and the privilege of the issuing store. As an entry is written, the block computes a 7-bit SEC-DED check word for each 32-bit half of the data. It also computes an even-parity bit over the address-and-mask field. An error-injection control can corrupt either kind of protection on the way into the array, so that the detection path can be exercised.

Entries leave the buffer in two ways. The first is when a fill lands on a slot that still holds a valid store. The second is a periodic drain that runs at a programmable rate. A draining ordinary store is decoded and may raise a correctable, uncorrectable or address-parity event, reported as a one-cycle pulse with the entry index. A parity event also carries the highest privilege code held among the valid entries. An entry is always invalidated when it drains. Writing stores back to memory and delivering traps are handled outside this block.

Top module: `stb_ecc_array`

## Requirements
- R1: A single write pointer, starting at 0 after reset, picks the fill slot and advances by one modulo 8 after each accepted fill. A fill that lands on a valid ordinary (non-alternate-space) slot drains and checks that slot first.
- R2: Each 32-bit data half has its own 7-bit SEC-DED check word. When a drained entry has a one-bit difference in a check word, a correctable event results. A two-bit difference gives an uncorrectable event. An intact entry gives no event. Uncorrectable in either half outranks correctable, so at most one of the two flags is set.
- R3: When inj_en and inj_data_sel are both 1, both check words are XORed with inj_mask before they are stored. With inj_en at 0, the selects and the mask have no effect.
- R4: The stored parity bit is even parity over {fill_addr, fill_mark}, inverted when inj_en and inj_addr_sel are both 1. A mismatch on drain raises err_par. If that drain was caused by a fill, the fill is aborted: fill_abort pulses, the new store is dropped, the pointer holds, and the slot ends up empty.
- R5: Each entry keeps a privilege code: 00 user, 01 privileged, 10 hyper-privileged (chosen when fill_hpriv is 1, whatever fill_priv is), and 11 unknown. With err_par, err_priv gives the largest code among all valid entries at the time of the drain, the draining entry included.
- R6: Each event is reported only while its enable (en_ue, en_ce, en_par) is 1. An entry with an uncorrectable error and en_ue at 0 reports neither flag. A disabled parity event does not abort the fill.
- R7: Alternate-space entries are never checked. A fill or periodic drain that meets one removes it silently.
- R8: With drain_rate N > 0 and no fills, the entry at the pointer drains every N cycles and the pointer advances. N = 0 turns the periodic drain off. A fill in the cycle the drain falls due postpones the drain.
- R9: err_ue, err_ce, err_par, err_idx, err_priv and fill_abort are registered. They reflect the drain made at a clock edge and are visible until the next edge only.
- R10: A drained entry is invalidated whether or not it reported, so its error is never reported twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Store fill request this cycle |
| fill_addr | input | ADDR_W | Store address |
| fill_mark | input | 8 | Byte mask, or alternate-space number |
| fill_data | input | 64 | Store data |
| fill_alt | input | 1 | Store targets an alternate space |
| fill_hpriv | input | 1 | Issuer is hyper-privileged |
| fill_priv | input | 1 | Issuer is privileged |
| inj_en | input | 1 | Error-injection master enable |
| inj_data_sel | input | 1 | Corrupt check words on write |
| inj_addr_sel | input | 1 | Invert address parity on write |
| inj_mask | input | 7 | XOR mask for check words |
| en_ue | input | 1 | Report uncorrectable events |
| en_ce | input | 1 | Report correctable events |
| en_par | input | 1 | Report address-parity events |
| drain_rate | input | RATE_W | Periodic drain interval in cycles, 0 = off |
| err_ue | output | 1 | Uncorrectable event pulse |
| err_ce | output | 1 | Correctable event pulse |
| err_par | output | 1 | Address-parity event pulse |
| err_idx | output | 3 | Index of the drained entry |
| err_priv | output | 2 | Highest privilege code, valid with err_par |
| fill_abort | output | 1 | Fill dropped because of a parity event |

## Verification
The assertions assume that inputs change only between clock edges and that fill_valid is a plain level that is sampled once per edge. They also assume that drain_rate does not change while a drain count is in progress. The bench drives every input at the falling edge and changes drain_rate only while the periodic drain is off and its counter is idle. Fills are never issued during a periodic-drain window, so the drain spacing stays exact.

// File: rtl/stb_ecc_array.sv
module stb_ecc_array #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 40,
  parameter int RATE_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_valid,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [7:0]                   fill_mark,
  input  logic [63:0]                  fill_data,
  input  logic                         fill_alt,
  input  logic                         fill_hpriv,
  input  logic                         fill_priv,
  input  logic                         inj_en,
  input  logic                         inj_data_sel,
  input  logic                         inj_addr_sel,
  input  logic [6:0]                   inj_mask,
  input  logic                         en_ue,
  input  logic                         en_ce,
  input  logic                         en_par,
  input  logic [RATE_W-1:0]            drain_rate,
  output logic                         err_ue,
  output logic                         err_ce,
  output logic                         err_par,
  output logic [$clog2(ENTRIES)-1:0]   err_idx,
  output logic [1:0]                   err_priv,
  output logic                         fill_abort
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W + 8;

  function automatic logic [6:0] secded(input logic [31:0] d);
    logic [5:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < 39; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < 6; k++)
          if (p[k]) c[k] = c[k] ^ d[j];
        j++;
      end
    end
    return {^{d, c}, c};
  endfunction

  // returns {uncorrectable, correctable}
  function automatic logic [1:0] classify(input logic [31:0] d, input logic [6:0] chk);
    logic [6:0] diff;
    logic q;
    diff = secded(d) ^ chk;
    q = ^{d, chk};
    if (q) return (diff[5:0] > 6'd38) ? 2'b10 : 2'b01;
    return (diff[5:0] != 6'd0) ? 2'b10 : 2'b00;
  endfunction

  logic [63:0]       data_q [ENTRIES];
  logic [13:0]       ecc_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [1:0]        ctl_q  [ENTRIES];
  logic [ENTRIES-1:0] par_q, alt_q, valid_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [RATE_W-1:0] cnt_q;

  wire [IDX_W-1:0] ptr_nxt = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  wire rate_hit = (drain_rate != '0) && (cnt_q == drain_rate - RATE_W'(1));
  wire tick     = rate_hit && !fill_valid;
  wire checked  = (fill_valid || tick) && valid_q[ptr_q] && !alt_q[ptr_q];

  wire [1:0] cls_lo = classify(data_q[ptr_q][31:0],  ecc_q[ptr_q][6:0]);
  wire [1:0] cls_hi = classify(data_q[ptr_q][63:32], ecc_q[ptr_q][13:7]);
  wire ue_any  = cls_lo[1] | cls_hi[1];
  wire ce_any  = cls_lo[0] | cls_hi[0];
  wire par_bad = (^tag_q[ptr_q]) != par_q[ptr_q];

  wire ue_ev  = checked && ue_any && en_ue;
  wire ce_ev  = checked && !ue_any && ce_any && en_ce;
  wire par_ev = checked && par_bad && en_par;
  wire abort  = fill_valid && par_ev;

  wire [6:0] inj_x = (inj_en && inj_data_sel) ? inj_mask : 7'd0;
  wire [1:0] new_ctl = fill_hpriv ? 2'b10 : (fill_priv ? 2'b01 : 2'b00);

  logic [1:0] priv_max;
  always_comb begin
    priv_max = 2'b00;
    for (int i = 0; i < ENTRIES; i++)
      if (valid_q[i] && ctl_q[i] > priv_max) priv_max = ctl_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (drain_rate == '0)  cnt_q <= '0;
      else if (tick)         cnt_q <= '0;
      else if (!rate_hit)    cnt_q <= cnt_q + 1'b1;
      if (fill_valid) begin
        if (abort) valid_q[ptr_q] <= 1'b0;
        else begin
          valid_q[ptr_q] <= 1'b1;
          ptr_q <= ptr_nxt;
        end
      end else if (tick) begin
        valid_q[ptr_q] <= 1'b0;
        ptr_q <= ptr_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !abort) begin
      data_q[ptr_q] <= fill_data;
      ecc_q[ptr_q]  <= {secded(fill_data[63:32]) ^ inj_x, secded(fill_data[31:0]) ^ inj_x};
      tag_q[ptr_q]  <= {fill_addr, fill_mark};
      par_q[ptr_q]  <= (^{fill_addr, fill_mark}) ^ (inj_en && inj_addr_sel);
      ctl_q[ptr_q]  <= new_ctl;
      alt_q[ptr_q]  <= fill_alt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_ue <= 1'b0; err_ce <= 1'b0; err_par <= 1'b0;
      err_idx <= '0; err_priv <= 2'b00; fill_abort <= 1'b0;
    end else begin
      err_ue     <= ue_ev;
      err_ce     <= ce_ev;
      err_par    <= par_ev;
      err_idx    <= ptr_q;
      err_priv   <= par_ev ? priv_max : 2'b00;
      fill_abort <= abort;
    end
  end

  // R2
  ue_ce_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(err_ue && err_ce));
  // R4
  abort_needs_par_chk: assert property (@(posedge clk) disable iff (!rst_n) fill_abort |-> err_par);
  // R4
  abort_holds_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_abort |-> ptr_q == $past(ptr_q));
  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid) && !fill_abort) |->
      ptr_q == (($past(ptr_q) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ptr_q) + 1'b1));
  // R10
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_abort |-> !valid_q[err_idx]);
  // R6
  par_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_par |-> $past(en_par));
endmodule

// File: tb/stb_ecc_array_tb_top.sv
module stb_ecc_array_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic fill_valid = 0, fill_alt = 0, fill_hpriv = 0, fill_priv = 0;
  logic [39:0] fill_addr = '0;
  logic [7:0] fill_mark = '0;
  logic [63:0] fill_data = '0;
  logic inj_en = 0, inj_data_sel = 0, inj_addr_sel = 0;
  logic [6:0] inj_mask = '0;
  logic en_ue = 1, en_ce = 1, en_par = 1;
  logic [15:0] drain_rate = '0;
  logic err_ue, err_ce, err_par, fill_abort;
  logic [2:0] err_idx;
  logic [1:0] err_priv;

  int checks = 0, errors = 0;

  stb_ecc_array dut_i (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_mark(fill_mark), .fill_data(fill_data), .fill_alt(fill_alt),
    .fill_hpriv(fill_hpriv), .fill_priv(fill_priv), .inj_en(inj_en),
    .inj_data_sel(inj_data_sel), .inj_addr_sel(inj_addr_sel), .inj_mask(inj_mask),
    .en_ue(en_ue), .en_ce(en_ce), .en_par(en_par), .drain_rate(drain_rate),
    .err_ue(err_ue), .err_ce(err_ce), .err_par(err_par), .err_idx(err_idx),
    .err_priv(err_priv), .fill_abort(fill_abort));

  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ev = {ue, ce, par, abort}
  function automatic int ev();
    return {28'd0, err_ue, err_ce, err_par, fill_abort};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fill_valid = 0; inj_en = 0; inj_data_sel = 0; inj_addr_sel = 0;
    inj_mask = '0; en_ue = 1; en_ce = 1; en_par = 1; drain_rate = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(input logic alt, input logic hp, input logic pv,
                      input logic dinj, input logic ainj, input logic [6:0] mask);
    @(negedge clk);
    fill_valid = 1; fill_alt = alt; fill_hpriv = hp; fill_priv = pv;
    fill_addr = 40'h12_3456_7000 + 40'(checks * 8); fill_mark = 8'h0F;
    fill_data = 64'h0123_4567_89AB_CDEF ^ 64'(checks * 977);
    inj_en = dinj | ainj; inj_data_sel = dinj; inj_addr_sel = ainj; inj_mask = mask;
    @(posedge clk); #1;
    fill_valid = 0; inj_en = 0; inj_data_sel = 0; inj_addr_sel = 0;
  endtask

  task automatic fill_clean(input int n);
    for (int i = 0; i < n; i++) fill(0, 0, 0, 0, 0, 7'd0);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(ev() == 0 && err_idx == 0, "R9 reset outputs", ev(), 0);
  endtask

  task automatic t_clean_wrap();
    do_reset();
    fill_clean(8);
    fill_clean(1);
    check(ev() == 0, "R1 R2 clean slot drained silently", ev(), 0);
  endtask

  task automatic t_ce();
    do_reset();
    fill(0, 0, 0, 1, 0, 7'b0000100);
    fill_clean(7);
    fill_clean(1);
    check(ev() == 4'b0100, "R2 single-bit gives correctable", ev(), 4);
    check(err_idx == 0, "R1 event index of slot 0", err_idx, 0);
    @(posedge clk); #1;
    check(ev() == 0, "R9 event lasts one cycle", ev(), 0);
  endtask

  task automatic t_ovr_ce();
    do_reset();
    fill(0, 0, 0, 1, 0, 7'b1000000);
    fill_clean(8);
    check(ev() == 4'b0100, "R2 overall check bit flip correctable", ev(), 4);
  endtask

  task automatic t_ue();
    do_reset();
    fill_clean(1);
    fill(0, 0, 0, 1, 0, 7'b0000011);
    fill_clean(6);
    fill_clean(1);
    check(ev() == 0, "R2 slot 0 clean", ev(), 0);
    fill_clean(1);
    check(ev() == 4'b1000, "R2 double-bit gives uncorrectable only", ev(), 8);
    check(err_idx == 1, "R1 event index of slot 1", err_idx, 1);
  endtask

  task automatic t_inj_off();
    do_reset();
    @(negedge clk);
    fill_valid = 1; fill_alt = 0; fill_hpriv = 0; fill_priv = 0;
    inj_en = 0; inj_data_sel = 1; inj_addr_sel = 1; inj_mask = 7'b0000011;
    @(posedge clk); #1;
    fill_valid = 0; inj_data_sel = 0; inj_addr_sel = 0;
    fill_clean(8);
    check(ev() == 0, "R3 selects ignored while injection off", ev(), 0);
  endtask

  task automatic t_parity();
    do_reset();
    fill(0, 0, 0, 0, 1, 7'd0);
    fill(0, 0, 0, 1, 0, 7'b0010000);
    fill(0, 1, 1, 0, 0, 7'd0);
    for (int i = 0; i < 5; i++) fill(0, 0, 1, 0, 0, 7'd0);
    fill_clean(1);
    check(ev() == 4'b0011, "R4 parity mismatch aborts fill", ev(), 3);
    check(err_priv == 2'b10, "R5 hyper-privileged is highest", err_priv, 2);
    check(err_idx == 0, "R4 parity index", err_idx, 0);
    fill_clean(1);
    check(ev() == 0, "R10 aborted slot empty, refill silent", ev(), 0);
    fill_clean(1);
    check(ev() == 4'b0100 && err_idx == 1, "R4 pointer held after abort", ev(), 4);
  endtask

  task automatic t_priv_mix();
    do_reset();
    fill(0, 0, 0, 0, 1, 7'd0);
    for (int i = 1; i < 8; i++) fill(0, 0, (i == 5), 0, 0, 7'd0);
    fill_clean(1);
    check(err_par && err_priv == 2'b01, "R5 privileged is highest", err_priv, 1);
  endtask

  task automatic t_enables();
    do_reset();
    fill(0, 0, 0, 1, 0, 7'b0000011);
    fill(0, 0, 0, 0, 1, 7'd0);
    fill_clean(6);
    @(negedge clk); en_ue = 0; en_par = 0;
    fill_clean(1);
    check(ev() == 0, "R6 ue disabled hides ue and ce", ev(), 0);
    fill_clean(1);
    check(ev() == 0, "R6 parity disabled no abort", ev(), 0);
  endtask

  task automatic t_alt();
    do_reset();
    fill(1, 0, 0, 1, 1, 7'b0000011);
    fill_clean(7);
    fill_clean(1);
    check(ev() == 0, "R7 alternate-space slot unchecked", ev(), 0);
  endtask

  task automatic t_periodic();
    int first, last, cnt;
    logic order_ok;
    do_reset();
    for (int i = 0; i < 8; i++) fill(0, 0, 0, 1, 0, 7'b0001000);
    @(negedge clk); drain_rate = 16'd4;
    first = -1; last = -1; cnt = 0; order_ok = 1;
    for (int c = 1; c <= 60; c++) begin
      @(posedge clk); #1;
      if (err_ce) begin
        if (first < 0) first = c;
        else if (c - last != 4) order_ok = 0;
        if (err_idx != 3'(cnt)) order_ok = 0;
        last = c; cnt++;
      end
    end
    @(negedge clk); drain_rate = 16'd0;
    check(first == 4, "R8 first drain after rate cycles", first, 4);
    check(order_ok, "R8 spacing and order of periodic drain", order_ok, 1);
    check(cnt == 8, "R10 each entry reported once", cnt, 8);
    @(posedge clk); #1;
    fill_clean(1);
    check(ev() == 0, "R8 drained slots empty", ev(), 0);
  endtask

  initial begin
    t_reset();
    t_clean_wrap();
    t_ce();
    t_ovr_ce();
    t_ue();
    t_inj_off();
    t_parity();
    t_priv_mix();
    t_enables();
    t_alt();
    t_periodic();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule